// File: doc/BRIEF.md
# Shared-Adder Loop Index Unit

This block tracks the iteration index of every loop in a loop nest with a single adder and a single equality comparator shared by all loops. Each loop has a start value, a signed increment and a last value. These sit in three small parameter stores that can be rewritten at any time, so loop bounds may be changed while the nest runs. The current indices live in an index store written through one port. Beside each index sits a one-bit end flag, which says the stored index is already the loop's last value.

A sequencer names the loop whose backward task is running on `sel_loop`. When that task finishes it pulses `bwd_done`. If the selected loop's end flag is clear, the index advances by the increment. If the flag is set, the loop has just run its last iteration, and its index is reloaded with the start value, ready for the next entry. In both cases the flag is recomputed from the new value, so the end of a loop is known one iteration before it happens. Writing a loop's start value also places that loop at its start. Address generators read the selected loop's index on `cur_index`. When bank mode is enabled, they can also read every index at once on `all_index`.

Top module: `loop_index_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, every index reads 0 and every end flag reads 0 until the first write or update.
- R2: A parameter write with `prm_kind` = 0 (start value) to loop A, in a cycle without `bwd_done`, stores the value and sets A's index to it one cycle later. A's end flag becomes 1 exactly when that value equals A's stored last value.
- R3: A parameter write with `prm_kind` = 1 (increment) or `prm_kind` = 2 (last value) changes only the parameter store. No index and no end flag moves.
- R4: On `bwd_done` with the selected loop's end flag clear, that loop's index becomes index + increment modulo 2^IDX_W. The increment is a two's-complement signed value.
- R5: After every update caused by `bwd_done`, the selected loop's end flag equals 1 exactly when its new index equals its last value as stored before that cycle.
- R6: On `bwd_done` with the selected loop's end flag set, the index is reloaded with the start value. A loop whose start value equals its last value therefore keeps its flag set.
- R7: A `bwd_done` changes the index and the end flag of the selected loop only.
- R8: When `bwd_done` and a parameter write fall in the same cycle, the parameter is stored. The update uses the parameters as they were before that cycle, and a start-value write in that cycle does not reposition its loop.
- R9: `cur_index` shows the stored index of the loop on `sel_loop` combinationally. With BANK_MODE=1, `all_index` carries loop k's index at bits [k*IDX_W +: IDX_W].
- R10: A new increment or last value written while a loop runs takes effect from that loop's next update.
- R11: A parameter write with `prm_kind` = 3 changes no store, no index and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_loop | input | clog2(N_LOOPS) | Loop whose backward task is running |
| bwd_done | input | 1 | Backward task of the selected loop finished |
| prm_we | input | 1 | Parameter write strobe |
| prm_kind | input | 2 | 0 start value, 1 increment, 2 last value, 3 reserved |
| prm_addr | input | clog2(N_LOOPS) | Loop addressed by the parameter write |
| prm_wdata | input | IDX_W | Parameter value |
| cur_index | output | IDX_W | Index of the selected loop |
| end_flags | output | N_LOOPS | Per-loop flag: index equals last value |
| all_index | output | N_LOOPS*IDX_W | All indices (bank mode), else zero |

## Verification
The assertions check, on every cycle, the step arithmetic, the reload on a set flag, the flag against the last value, the landing of start-value writes, and that no flag or index moves without a cause. They also check that a single update disturbs no other loop. Only the bench's scenarios show the longer effects. These include a loop run past its last value and around again, index wrap-around across zero, a start value equal to the last value, and parameters rewritten mid-run becoming visible at a later update. They also include a start-value write that collides with an update and is later seen only through a reload.

// File: rtl/loop_idx_pkg.sv
`timescale 1ns/1ps
package loop_idx_pkg;

  typedef enum logic [1:0] {
    PK_INIT  = 2'd0,
    PK_STEP  = 2'd1,
    PK_FINAL = 2'd2,
    PK_RSVD  = 2'd3
  } prm_kind_e;

  function automatic int addr_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/loop_param_store.sv
`timescale 1ns/1ps
module loop_param_store
  import loop_idx_pkg::*;
#(
  parameter int N_LOOPS = 8,
  parameter int IDX_W   = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [addr_w(N_LOOPS)-1:0]    wr_addr,
  input  logic [IDX_W-1:0]              wr_data,
  input  logic [addr_w(N_LOOPS)-1:0]    rd_addr,
  output logic [IDX_W-1:0]              rd_data
);

  localparam int AW    = addr_w(N_LOOPS);
  localparam int DEPTH = 1 << AW;

  logic [IDX_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];

  AST_PARAM_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data)); // R10

endmodule

// File: rtl/loop_index_store.sv
`timescale 1ns/1ps
module loop_index_store
  import loop_idx_pkg::*;
#(
  parameter int N_LOOPS   = 8,
  parameter int IDX_W     = 16,
  parameter int BANK_MODE = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [addr_w(N_LOOPS)-1:0]    wr_addr,
  input  logic [IDX_W-1:0]              wr_data,
  input  logic [addr_w(N_LOOPS)-1:0]    rd_addr,
  output logic [IDX_W-1:0]              rd_data,
  output logic [N_LOOPS*IDX_W-1:0]      all_data
);

  localparam int AW    = addr_w(N_LOOPS);
  localparam int DEPTH = 1 << AW;

  logic [IDX_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];

  generate
    if (BANK_MODE != 0) begin : g_bank
      for (genvar g = 0; g < N_LOOPS; g++) begin : g_out
        assign all_data[g*IDX_W +: IDX_W] = mem_q[g];
      end
    end else begin : g_file
      assign all_data = '0;
    end
  endgenerate

  AST_IDX_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data)); // R4

endmodule

// File: rtl/loop_end_flags.sv
`timescale 1ns/1ps
module loop_end_flags
  import loop_idx_pkg::*;
#(
  parameter int N_LOOPS = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [addr_w(N_LOOPS)-1:0]          wr_addr,
  input  logic                                wr_val,
  output logic [(1 << addr_w(N_LOOPS))-1:0]   flags
);

  localparam int AW    = addr_w(N_LOOPS);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0] sel_mask;
  logic [DEPTH-1:0] flg_d;
  logic [DEPTH-1:0] flg_q;

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_dec
      assign sel_mask[g] = (wr_addr == AW'(g));
    end
  endgenerate

  always_comb begin
    flg_d = (flg_q & ~sel_mask) | (sel_mask & {DEPTH{wr_val}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else if (wr_en) flg_q <= flg_d;
  end

  assign flags = flg_q;

  AST_OTHER_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((flg_q ^ $past(flg_q)) & ~$past(sel_mask)) == '0); // R7

  AST_ONE_FLAG_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flg_q ^ $past(flg_q)) <= 1); // R7

endmodule

// File: rtl/loop_next_calc.sv
`timescale 1ns/1ps
module loop_next_calc #(
  parameter int IDX_W = 16
) (
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [IDX_W-1:0] step,
  input  logic [IDX_W-1:0] init_val,
  input  logic [IDX_W-1:0] final_val,
  input  logic             at_end,
  input  logic             arm,
  input  logic [IDX_W-1:0] arm_val,
  output logic [IDX_W-1:0] nxt_idx,
  output logic             nxt_is_final
);

  logic [IDX_W-1:0] stepped;
  logic [IDX_W-1:0] advanced;

  always_comb begin
    stepped      = cur_idx + step;
    advanced     = at_end ? init_val : stepped;
    nxt_idx      = arm ? arm_val : advanced;
    nxt_is_final = (nxt_idx == final_val);
  end

endmodule

// File: rtl/loop_index_unit.sv
`timescale 1ns/1ps
module loop_index_unit
  import loop_idx_pkg::*;
#(
  parameter int N_LOOPS   = 8,
  parameter int IDX_W     = 16,
  parameter int BANK_MODE = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [addr_w(N_LOOPS)-1:0]    sel_loop,
  input  logic                          bwd_done,
  input  logic                          prm_we,
  input  logic [1:0]                    prm_kind,
  input  logic [addr_w(N_LOOPS)-1:0]    prm_addr,
  input  logic [IDX_W-1:0]              prm_wdata,
  output logic [IDX_W-1:0]              cur_index,
  output logic [N_LOOPS-1:0]            end_flags,
  output logic [N_LOOPS*IDX_W-1:0]      all_index
);

  localparam int AW    = addr_w(N_LOOPS);
  localparam int DEPTH = 1 << AW;

  prm_kind_e        kind;
  logic             we_init, we_step, we_final;
  logic             arm;
  logic             upd_en;
  logic [AW-1:0]    upd_addr;
  logic [AW-1:0]    fin_addr;
  logic [IDX_W-1:0] init_rd, step_rd, fin_rd;
  logic [IDX_W-1:0] nxt_idx;
  logic             nxt_is_final;
  logic [DEPTH-1:0] flags_all;
  logic             at_end;

  assign kind     = prm_kind_e'(prm_kind);
  assign we_init  = prm_we && (kind == PK_INIT);
  assign we_step  = prm_we && (kind == PK_STEP);
  assign we_final = prm_we && (kind == PK_FINAL);

  // start-value write repositions its loop only when no update competes
  assign arm      = we_init && !bwd_done;
  assign upd_en   = bwd_done || arm;
  assign upd_addr = bwd_done ? sel_loop : prm_addr;
  assign fin_addr = arm ? prm_addr : sel_loop;

  loop_param_store #(.N_LOOPS(N_LOOPS), .IDX_W(IDX_W)) u_init (
    .clk(clk), .rst_n(rst_n), .wr_en(we_init), .wr_addr(prm_addr),
    .wr_data(prm_wdata), .rd_addr(sel_loop), .rd_data(init_rd));

  loop_param_store #(.N_LOOPS(N_LOOPS), .IDX_W(IDX_W)) u_step (
    .clk(clk), .rst_n(rst_n), .wr_en(we_step), .wr_addr(prm_addr),
    .wr_data(prm_wdata), .rd_addr(sel_loop), .rd_data(step_rd));

  loop_param_store #(.N_LOOPS(N_LOOPS), .IDX_W(IDX_W)) u_final (
    .clk(clk), .rst_n(rst_n), .wr_en(we_final), .wr_addr(prm_addr),
    .wr_data(prm_wdata), .rd_addr(fin_addr), .rd_data(fin_rd));

  loop_index_store #(.N_LOOPS(N_LOOPS), .IDX_W(IDX_W), .BANK_MODE(BANK_MODE)) u_idx (
    .clk(clk), .rst_n(rst_n), .wr_en(upd_en), .wr_addr(upd_addr),
    .wr_data(nxt_idx), .rd_addr(sel_loop), .rd_data(cur_index),
    .all_data(all_index));

  loop_end_flags #(.N_LOOPS(N_LOOPS)) u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(upd_en), .wr_addr(upd_addr),
    .wr_val(nxt_is_final), .flags(flags_all));

  assign at_end    = flags_all[sel_loop];
  assign end_flags = flags_all[N_LOOPS-1:0];

  loop_next_calc #(.IDX_W(IDX_W)) u_calc (
    .cur_idx(cur_index), .step(step_rd), .init_val(init_rd),
    .final_val(fin_rd), .at_end(at_end), .arm(arm), .arm_val(prm_wdata),
    .nxt_idx(nxt_idx), .nxt_is_final(nxt_is_final));

  AST_ARM_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (sel_loop != $past(prm_addr)) || (cur_index == $past(prm_wdata))); // R2

  AST_QUIET_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bwd_done && !we_init) |=> flags_all == $past(flags_all)); // R3

  AST_QUIET_HOLDS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (!bwd_done && !we_init) |=> (sel_loop != $past(sel_loop)) || (cur_index == $past(cur_index))); // R3

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (bwd_done && !at_end) |=> (sel_loop != $past(sel_loop)) || (cur_index == $past(cur_index + step_rd))); // R4

  AST_FLAG_TRACKS_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    (bwd_done && !prm_we) |=> (sel_loop != $past(sel_loop)) || arm
                              || (flags_all[sel_loop] == (cur_index == fin_rd))); // R5

  AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (bwd_done && at_end) |=> (sel_loop != $past(sel_loop)) || (cur_index == $past(init_rd))); // R6

endmodule

// File: tb/sim_loop_index_unit.sv
`timescale 1ns/1ps
module sim_loop_index_unit;

  localparam int N = 8;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [2:0]     sel_loop = '0;
  logic           bwd_done = 1'b0;
  logic           prm_we = 1'b0;
  logic [1:0]     prm_kind = '0;
  logic [2:0]     prm_addr = '0;
  logic [W-1:0]   prm_wdata = '0;
  logic [W-1:0]   cur_index;
  logic [N-1:0]   end_flags;
  logic [N*W-1:0] all_index;

  loop_index_unit #(.N_LOOPS(N), .IDX_W(W), .BANK_MODE(1)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_loop(sel_loop), .bwd_done(bwd_done),
    .prm_we(prm_we), .prm_kind(prm_kind), .prm_addr(prm_addr),
    .prm_wdata(prm_wdata), .cur_index(cur_index), .end_flags(end_flags),
    .all_index(all_index));

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model
  logic [W-1:0] mi [N];
  logic         mf [N];
  logic [W-1:0] minit [N];
  logic [W-1:0] mstep [N];
  logic [W-1:0] mfin [N];

  typedef struct {
    int           due;
    int           lp;
    logic [W-1:0] idx;
    logic         flg;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  // monitor: pops expected items once their result cycle is reached
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        logic [W-1:0] got_i;
        logic         got_f;
        e     = q.pop_front();
        got_i = all_index[e.lp*W +: W];
        got_f = end_flags[e.lp];
        n_chk++;
        if (got_i !== e.idx || got_f !== e.flg) begin
          n_bad++;
          $display("FAIL %s loop %0d: got index %h flag %b, expected index %h flag %b",
                   e.tag, e.lp, got_i, got_f, e.idx, e.flg);
        end
      end
    end
  end

  task automatic push_all(input int due, input string tag);
    for (int l = 0; l < N; l++) begin
      exp_t e;
      e.due = due; e.lp = l; e.idx = mi[l]; e.flg = mf[l]; e.tag = tag;
      q.push_back(e);
    end
  endtask

  // driver: one clock of stimulus, model update, expected items queued
  task automatic drive(input bit b, input int bl, input bit w, input int k,
                       input int wa, input logic [W-1:0] wd, input string tag);
    @(negedge clk);
    sel_loop  = 3'(bl);
    bwd_done  = b;
    prm_we    = w;
    prm_kind  = 2'(k);
    prm_addr  = 3'(wa);
    prm_wdata = wd;
    if (b) begin
      logic [W-1:0] n;
      n = mf[bl] ? minit[bl] : mi[bl] + mstep[bl];
      mi[bl] = n;
      mf[bl] = (n == mfin[bl]);
    end
    if (w) begin
      case (k)
        0: minit[wa] = wd;
        1: mstep[wa] = wd;
        2: mfin[wa]  = wd;
        default: ;
      endcase
      if (k == 0 && !b) begin
        mi[wa] = wd;
        mf[wa] = (wd == mfin[wa]);
      end
    end
    push_all(cyc + 1, tag);
    @(posedge clk);
    #1;
    bwd_done = 1'b0;
    prm_we   = 1'b0;
  endtask

  task automatic bwd(input int l, input string tag);
    drive(1'b1, l, 1'b0, 0, 0, '0, tag);
  endtask

  task automatic wr(input int k, input int a, input logic [W-1:0] d, input string tag);
    drive(1'b0, 0, 1'b1, k, a, d, tag);
  endtask

  task automatic chk_cur(input int l, input string tag);
    @(negedge clk);
    sel_loop = 3'(l);
    #1;
    n_chk++;
    if (cur_index !== mi[l]) begin
      n_bad++;
      $display("FAIL %s cur_index loop %0d: got %h, expected %h", tag, l, cur_index, mi[l]);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout, expected completion");
      finish_run();
    end
  end

  initial begin
    for (int l = 0; l < N; l++) begin
      mi[l] = '0; mf[l] = 1'b0; minit[l] = '0; mstep[l] = '0; mfin[l] = '0;
    end
    // R1: reset state
    repeat (2) @(negedge clk);
    push_all(cyc, "R1");
    chk_cur(0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    push_all(cyc + 2, "R1");
    repeat (2) @(negedge clk);

    // R2/R3: configure loops; last value first so arming sees it
    wr(2, 0, 16'd3, "R3");      wr(1, 0, 16'd1, "R3");      wr(0, 0, 16'd0, "R2");
    wr(2, 1, 16'd4, "R3");      wr(1, 1, 16'hFFFE, "R3");   wr(0, 1, 16'd10, "R2");
    wr(2, 2, 16'd5, "R3");      wr(1, 2, 16'd3, "R3");      wr(0, 2, 16'd5, "R2");
    wr(2, 3, 16'd1, "R3");      wr(1, 3, 16'd1, "R3");      wr(0, 3, 16'hFFFE, "R2");
    wr(1, 4, 16'd7, "R3");      wr(2, 4, 16'd9, "R3");
    // R11: reserved kind touches nothing
    wr(3, 0, 16'h0055, "R11");
    chk_cur(1, "R2");

    // R4/R5/R6: descending loop with signed step, then reload
    for (int i = 0; i < 4; i++) bwd(1, "R4_R5_R6");
    chk_cur(1, "R9");
    // R6: single-iteration loop keeps its flag
    bwd(2, "R6"); bwd(2, "R6");
    // R4: wrap-around through zero
    for (int i = 0; i < 5; i++) bwd(3, "R4_R5");
    chk_cur(3, "R9");

    // R7: nested pattern, outer loop 0, inner loop 1
    for (int o = 0; o < 4; o++) begin
      for (int i = 0; i < 4; i++) bwd(1, "R7");
      bwd(0, "R7");
    end
    chk_cur(0, "R9");

    // R8: update and start-value write in the same cycle
    drive(1'b1, 0, 1'b1, 0, 0, 16'd2, "R8");
    drive(1'b1, 1, 1'b1, 0, 5, 16'd9, "R8");
    wr(2, 5, 16'd0, "R8");
    bwd(5, "R8"); bwd(5, "R8"); bwd(5, "R8");
    for (int i = 0; i < 5; i++) bwd(0, "R8_R6");

    // R10: increment and last value rewritten mid-run
    wr(1, 0, 16'd2, "R10");
    bwd(0, "R10");
    wr(2, 0, 16'd8, "R10");
    for (int i = 0; i < 4; i++) bwd(0, "R10");
    chk_cur(0, "R9");
    chk_cur(5, "R9");

    repeat (3) @(negedge clk);
    n_chk++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: got %0d pending items, expected 0", q.size());
    end
    done = 1'b1;
    finish_run();
  end

endmodule